// File: doc/BRIEF.md
# Dual Buffer Serial Read Port

This block serves reads from either of two on-chip byte buffers over a bit-serial command interface. The serial clock is the block clock: while the active-low select `csN` is low, every rising edge of `clk` samples one bit of `serIn`, most significant bit first. A transaction starts with an eight-bit command. The command picks one of the two buffers and a speed class. Three address bytes follow, and then, for the fast class only, one dummy byte. After that the block streams buffer bytes out on `serOut`, MSB first, from the start address onward. It keeps going until `csN` rises.

The buffers themselves sit outside the block and are reached through a read-only port (`bufSel`, `bufAddr`, `bufRdEn`, `bufData`). Read data is expected combinationally in the same cycle. The buffer holds 1056 bytes or 1024 bytes, set by `binaryPage`. That input also sets how many of the 24 address bits form the byte address. The rest of the address bits are ignored. The block has no write path, so a read cannot alter buffer contents. High impedance on the serial output is signalled by `serOutEn` low, which a pad driver uses to release the pin.

Top module: `bufrd_top`

## Requirements
- R1: Commands 0xD4, 0xD1 and 0x54 read buffer 1 (`bufSel`=0). Commands 0xD6, 0xD3 and 0x56 read buffer 2 (`bufSel`=1).
- R2: The fast commands 0xD4, 0xD6, 0x54 and 0x56 take 8 dummy bits after the address. The first data bit is visible after rising edge 40 of the transaction. The slow commands 0xD1 and 0xD3 show the first data bit after edge 32. Edge 1 is the first edge with `csN` low.
- R3: With `binaryPage`=0, the start address is the last 11 of the 24 address bits received. The first 13 bits have no effect.
- R4: With `binaryPage`=1, the start address is the last 10 of the 24 address bits received. The first 14 bits have no effect.
- R5: Data bytes leave MSB first, one bit per cycle, from consecutive buffer addresses beginning at the start address.
- R6: After address 1055 (`binaryPage`=0) or 1023 (`binaryPage`=1), the next byte read is address 0.
- R7: While `csN` is high, `serOutEn` and `bufRdEn` are low. The next low period of `csN` starts a new transaction at its command byte.
- R8: For any other command byte, `serOutEn` stays low until `csN` rises.
- R9: `serOutEn` and `bufRdEn` are low during the command, address and dummy bits.
- R10: After reset, `serOutEn` and `bufRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial/system clock; input sampled on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; high ends any transaction |
| serIn | input | 1 | Serial command/address input, MSB first |
| binaryPage | input | 1 | 1: 1024-byte buffers, 0: 1056-byte buffers |
| bufData | input | 8 | Byte read from the selected buffer at `bufAddr` |
| serOut | output | 1 | Serial data output, MSB first |
| serOutEn | output | 1 | Output driver enable; low means high impedance |
| bufRdEn | output | 1 | Buffer read strobe, high while data is streamed |
| bufSel | output | 1 | 0 selects buffer 1, 1 selects buffer 2 |
| bufAddr | output | 11 | Byte address within the selected buffer |

## Verification
The assertions take `binaryPage` to be steady for the whole of a transaction. They take `bufData` to be a pure combinational function of `bufSel` and `bufAddr`. They do not assume any relation between `csN` and the bit count, so an abort may fall anywhere. The stimulus changes `binaryPage` only while `csN` is high and drives every input on the falling clock edge. The buffer model computes each byte from the buffer number and address alone. One scenario raises `csN` in the middle of a byte.

// File: rtl/bufrd_pkg.sv
package bufrd_pkg;

  localparam int OPC_BITS = 8;

  localparam logic [7:0] OPC_B1_FAST = 8'hD4;
  localparam logic [7:0] OPC_B1_SLOW = 8'hD1;
  localparam logic [7:0] OPC_B2_FAST = 8'hD6;
  localparam logic [7:0] OPC_B2_SLOW = 8'hD3;
  localparam logic [7:0] OPC_B1_WIDE = 8'h54;
  localparam logic [7:0] OPC_B2_WIDE = 8'h56;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;

  typedef struct packed {
    logic       shiftEn;
    logic       loadPtr;
    logic       incPtr;
    logic       drive;
    logic [2:0] bitIdx;
  } dpCtrl_t;

endpackage

// File: rtl/bufrd_ctrl.sv
module bufrd_ctrl
  import bufrd_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic [7:0] opcNext,
  output dpCtrl_t    ctl,
  output logic       bufSel
);

  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             hiFreq;
  logic             opcValid, opcBuf2, opcFast;

  always_comb begin
    opcValid = 1'b1;
    opcBuf2  = 1'b0;
    opcFast  = 1'b0;
    case (opcNext)
      OPC_B1_FAST: opcFast = 1'b1;
      OPC_B1_SLOW: opcFast = 1'b0;
      OPC_B2_FAST: begin opcBuf2 = 1'b1; opcFast = 1'b1; end
      OPC_B2_SLOW: opcBuf2 = 1'b1;
      OPC_B1_WIDE: opcFast = 1'b1;
      OPC_B2_WIDE: begin opcBuf2 = 1'b1; opcFast = 1'b1; end
      default:     opcValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      hiFreq <= 1'b0;
      bufSel <= 1'b0;
    end else if (csN) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_CMD: begin
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            if (opcValid) begin
              phase  <= PH_ADDR;
              bufSel <= opcBuf2;
              hiFreq <= opcFast;
            end else begin
              phase <= PH_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt == ADDR_LAST) begin
            cnt   <= '0;
            phase <= hiFreq ? PH_DUMMY : PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == DUMMY_LAST) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: cnt <= cnt + 1'b1;
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    ctl.shiftEn = !csN && (phase == PH_CMD || phase == PH_ADDR);
    ctl.loadPtr = !csN && phase == PH_ADDR && cnt == ADDR_LAST;
    ctl.drive   = !csN && phase == PH_DATA;
    ctl.bitIdx  = cnt[2:0];
    ctl.incPtr  = ctl.drive && cnt[2:0] == 3'd7;
  end

  // R7: a high select returns the sequencer to the command byte
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> phase == PH_CMD);

  // R8: an unknown command parks the sequencer
  assert_bad_opcode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && phase == PH_CMD && cnt == CMD_LAST && !opcValid) |=> phase == PH_SKIP);

  // R9: data output only ever starts straight after address or dummy bits
  assert_quiet_preamble_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.drive) |-> ($past(phase) == PH_ADDR || $past(phase) == PH_DUMMY));

  // R2: fast commands always pass through the dummy phase
  assert_dummy_used_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadPtr && hiFreq) |=> (phase == PH_DUMMY || csN));

endmodule

// File: rtl/bufrd_datapath.sv
module bufrd_datapath
  import bufrd_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int ADDR_W    = 11,
  parameter int STD_BYTES = 1056,
  parameter int BIN_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              binaryPage,
  input  dpCtrl_t           ctl,
  input  logic [7:0]        bufData,
  output logic [7:0]        opcNext,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              serOut
);

  localparam int BIN_W = $clog2(BIN_BYTES);

  logic [ADDR_BITS-1:0] shReg, shNext;
  logic [ADDR_W-1:0]    addrPtr, lastAddr, startAddr;

  assign shNext    = {shReg[ADDR_BITS-2:0], serIn};
  assign opcNext   = shNext[OPC_BITS-1:0];
  assign lastAddr  = binaryPage ? ADDR_W'(BIN_BYTES - 1) : ADDR_W'(STD_BYTES - 1);
  assign startAddr = binaryPage ? ADDR_W'(shNext[BIN_W-1:0]) : shNext[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      addrPtr <= '0;
    end else begin
      if (ctl.shiftEn) shReg <= shNext;
      if (ctl.loadPtr) begin
        addrPtr <= startAddr;
      end else if (ctl.incPtr) begin
        addrPtr <= (addrPtr == lastAddr) ? '0 : addrPtr + 1'b1;
      end
    end
  end

  assign bufAddr = addrPtr;
  assign serOut  = ctl.drive & bufData[3'd7 - ctl.bitIdx];

  // R6: the pointer folds back to zero at the end of the buffer
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPtr && !ctl.loadPtr && addrPtr == lastAddr) |=> addrPtr == '0);

  // R5: the pointer moves only on a byte boundary or a fresh address
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.incPtr && !ctl.loadPtr) |=> $stable(addrPtr));

  // R4: in binary page mode the start address fits the smaller buffer
  assert_bin_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadPtr && binaryPage) |=> addrPtr < ADDR_W'(BIN_BYTES));

endmodule

// File: rtl/bufrd_top.sv
module bufrd_top
  import bufrd_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8,
  parameter int ADDR_W     = 11,
  parameter int STD_BYTES  = 1056,
  parameter int BIN_BYTES  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              serIn,
  input  logic              binaryPage,
  input  logic [7:0]        bufData,
  output logic              serOut,
  output logic              serOutEn,
  output logic              bufRdEn,
  output logic              bufSel,
  output logic [ADDR_W-1:0] bufAddr
);

  dpCtrl_t    ctl;
  logic [7:0] opcNext;

  bufrd_ctrl #(.ADDR_BITS(ADDR_BITS), .DUMMY_BITS(DUMMY_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .opcNext(opcNext),
    .ctl(ctl), .bufSel(bufSel)
  );

  bufrd_datapath #(.ADDR_BITS(ADDR_BITS), .ADDR_W(ADDR_W),
                   .STD_BYTES(STD_BYTES), .BIN_BYTES(BIN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .binaryPage(binaryPage),
    .ctl(ctl), .bufData(bufData), .opcNext(opcNext),
    .bufAddr(bufAddr), .serOut(serOut)
  );

  assign serOutEn = ctl.drive;
  assign bufRdEn  = ctl.drive;

  // R7: no output while deselected
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!serOutEn && !bufRdEn));

endmodule

// File: tb/tb_bufrd_top.sv
module tb_bufrd_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        serIn = 1'b0;
  logic        binaryPage = 1'b0;
  logic [7:0]  bufData;
  logic        serOut, serOutEn, bufRdEn, bufSel;
  logic [10:0] bufAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] bufByte(input logic sel, input int a);
    int v;
    v = sel ? (a * 13 + (a >> 8) * 59 + 90) : (a * 7 + (a >> 8) * 37 + 3);
    return v[7:0];
  endfunction

  assign bufData = bufByte(bufSel, int'(bufAddr));

  bufrd_top dut (
    .clk(clk), .rstN(rstN), .csN(csN), .serIn(serIn), .binaryPage(binaryPage),
    .bufData(bufData), .serOut(serOut), .serOutEn(serOutEn), .bufRdEn(bufRdEn),
    .bufSel(bufSel), .bufAddr(bufAddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readTxn(input logic [7:0] opc, input bit bin, input int upper,
                         input int start, input int nBytes, input int abortBits,
                         input bit fast, input bit expBuf2, input string req);
    logic [23:0] addr24;
    int size, loud;
    logic [7:0] got;
    addr24 = bin ? 24'((upper << 10) | start) : 24'((upper << 11) | start);
    size = bin ? 1024 : 1056;
    loud = 0;
    binaryPage = bin;
    @(negedge clk);
    csN = 1'b0;
    for (int k = 0; k < 32; k++) begin
      serIn = (k < 8) ? opc[7-k] : addr24[31-k];
      @(negedge clk);
      if ((k < 31 || fast) && (serOutEn || bufRdEn)) loud++;
    end
    if (fast) begin
      for (int d = 0; d < 8; d++) begin
        serIn = 1'b1;
        @(negedge clk);
        if (d < 7 && (serOutEn || bufRdEn)) loud++;
      end
    end
    chk(loud == 0, "R9 quiet preamble", loud, 0);
    chk(bufSel == expBuf2, {"R1 buffer select ", req}, int'(bufSel), int'(expBuf2));
    for (int b = 0; b < nBytes; b++) begin
      int en;
      en = 0;
      for (int i = 0; i < 8; i++) begin
        got[7-i] = serOut;
        if (serOutEn && bufRdEn) en++;
        @(negedge clk);
      end
      chk(en == 8, {"R2 output enabled ", req}, en, 8);
      chk(got == bufByte(expBuf2, (start + b) % size), {"R5 data byte ", req},
          int'(got), int'(bufByte(expBuf2, (start + b) % size)));
    end
    for (int i = 0; i < abortBits; i++) @(negedge clk);
    csN = 1'b1;
    #1;
    chk(!serOutEn && !bufRdEn, "R7 release on deselect", int'(serOutEn), 0);
    @(negedge clk);
  endtask

  task automatic badOpcode(input logic [7:0] opc);
    int loud;
    loud = 0;
    @(negedge clk);
    csN = 1'b0;
    for (int k = 0; k < 80; k++) begin
      serIn = (k < 8) ? opc[7-k] : k[0];
      @(negedge clk);
      if (serOutEn || bufRdEn) loud++;
    end
    chk(loud == 0, "R8 unknown command silent", loud, 0);
    csN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!serOutEn && !bufRdEn, "R10 reset state", int'(serOutEn), 0);

    // R2 R3: fast buffer 1, garbage in upper 13 bits
    readTxn(8'hD4, 1'b0, 13'h1ABC, 100, 3, 0, 1'b1, 1'b0, "R3 D4");
    // R6: slow buffer 1 wrapping at 1055
    readTxn(8'hD1, 1'b0, 13'h0F0F, 1053, 5, 0, 1'b0, 1'b0, "R6 D1 wrap 1056");
    // R4 R6: fast buffer 2 in binary mode, upper 14 bits ones, wrap at 1023
    readTxn(8'hD6, 1'b1, 14'h3FFF, 1021, 5, 0, 1'b1, 1'b1, "R4 D6 wrap 1024");
    // R2: slow buffer 2 in binary mode
    readTxn(8'hD3, 1'b1, 14'h1555, 7, 2, 0, 1'b0, 1'b1, "R2 D3");
    // R1: wide-bus command aliases
    readTxn(8'h54, 1'b0, 0, 2047 - 1000, 2, 0, 1'b1, 1'b0, "R1 54");
    readTxn(8'h56, 1'b1, 14'h2AAA, 512, 2, 0, 1'b1, 1'b1, "R1 56");
    // R8: command that is not a buffer read
    badOpcode(8'hD2);
    badOpcode(8'h0B);
    // R7: abort part way through a byte, then a fresh transaction
    readTxn(8'hD6, 1'b0, 13'h0001, 300, 2, 3, 1'b1, 1'b1, "R7 abort");
    readTxn(8'hD1, 1'b0, 13'h1FFF, 1055, 2, 0, 1'b0, 1'b0, "R7 restart");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule